// File: doc/BRIEF.md
# Error Window Settling Detector

This block watches a stream of signed error samples and decides when the error has settled close to zero. A small configuration word, written in one strobe, sets the error sign, switches detection on, and gives the half-width of an acceptance window and a sample-count limit. Each valid sample is first sign-corrected, with a saturating negation. Its magnitude is then compared against the window, and the result is debounced by a counter that only moves on sample strobes.

The `settled` output rises once the limit number of consecutive in-window samples has been seen. Once high, it falls only after the same number of consecutive out-of-window samples, so the flag has hysteresis in time. Detection is held off, with the flag low and the counter cleared, while the enable bit is clear or while an external ramp-busy input is high. A controller uses the flag to decide when the loop may take over from a pre-biased output.

Top module: `err_settle_det`

## Requirements
- R1: After reset `settled` is 0 and detection is disabled, so samples leave `settled` at 0 until a configuration word with the enable bit set is written.
- R2: A sample counts as in range when the magnitude of its sign-corrected error is less than or equal to the range field. An error equal to the range value is in range; one greater is out.
- R3: The configuration word has the enable in bit 0, the polarity in bit 1, the limit in bits 9:2 and the range in bits 17:10. With polarity 0 the sample is used as is. With polarity 1 it is negated, and the most negative code (-256) becomes +255 instead of wrapping.
- R4: While `settled` is 0, it becomes 1 on the limit-th consecutive in-range sample (limit of 1 or more).
- R5: While `settled` is 1, it becomes 0 on the limit-th consecutive out-of-range sample.
- R6: A sample that agrees with the current state of `settled` restarts the count, so only consecutive disagreeing samples count.
- R7: With a limit of 0, `settled` takes the in-range result of each sample directly.
- R8: Writing the enable bit to 0 clears `settled` and the counter. After re-enabling, counting starts from zero.
- R9: While `ramp_busy` is high, `settled` is 0 and the counter is held at zero.
- R10: Only cycles with `smp_valid` high are counted. `settled` changes only on the second clock edge after the edge that takes a sample, and it holds between samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 18 | Configuration word: en[0], pol[1], limit[9:2], range[17:10] |
| ramp_busy | input | 1 | High while the ramp runs; holds detection off |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 9 | Two's-complement error sample |
| settled | output | 1 | Registered settling status |

## Verification
The assertions check on every cycle that the flag stays low while the block is disabled or the ramp is busy, and that it holds between strobes. They also check that a zero limit makes the flag follow the latest in-range result, that a rise always follows an in-range strobe, and that an agreeing sample clears the counter. Only the bench scenarios can show the counting behaviour: that exactly the limit number of consecutive samples sets or clears the flag, that an interrupted run starts over, and that the window boundary and saturated negation land on the right side. They also show that the counter is really cleared across an enable toggle.

// File: rtl/esd_pkg.sv
package esd_pkg;

  localparam int unsigned DEF_SMP_W = 9;
  localparam int unsigned DEF_RNG_W = 8;
  localparam int unsigned DEF_LIM_W = 8;

  typedef enum logic {
    DEC_OPEN    = 1'b0,
    DEC_SETTLED = 1'b1
  } dec_e;

endpackage

// File: rtl/esd_cfg_reg.sv
module esd_cfg_reg #(
  parameter int unsigned RNG_W = 8,
  parameter int unsigned LIM_W = 8,
  localparam int unsigned CFG_W = 2 + RNG_W + LIM_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output logic             en_q,
  output logic             pol_q,
  output logic [RNG_W-1:0] rng_q,
  output logic [LIM_W-1:0] lim_q
);

  localparam int unsigned LIM_LO = 2;
  localparam int unsigned RNG_LO = 2 + LIM_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      pol_q <= 1'b0;
      rng_q <= '1;
      lim_q <= '0;
    end else if (wr) begin
      en_q  <= wdata[0];
      pol_q <= wdata[1];
      lim_q <= wdata[LIM_LO +: LIM_W];
      rng_q <= wdata[RNG_LO +: RNG_W];
    end
  end

  // R3: field positions of the written word
  a_r3_field_map: assert property (@(posedge clk) disable iff (rst)
    $past(wr) |-> (en_q == $past(wdata[0])) && (pol_q == $past(wdata[1])) &&
                  (lim_q == $past(wdata[LIM_LO +: LIM_W])) &&
                  (rng_q == $past(wdata[RNG_LO +: RNG_W])));

  // R1: configuration holds when not written
  a_r1_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(wr) && !$past(rst) |-> $stable(en_q) && $stable(rng_q));

endmodule

// File: rtl/esd_err_cond.sv
module esd_err_cond #(
  parameter int unsigned SMP_W = 9,
  parameter int unsigned RNG_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    pol,
  input  logic [RNG_W-1:0]        rng,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_data,
  output logic                    vld_q,
  output logic                    inr_q
);

  localparam int unsigned CMP_W = (SMP_W > RNG_W) ? SMP_W : RNG_W + 1;
  localparam logic signed [SMP_W-1:0] S_MIN = {1'b1, {(SMP_W-1){1'b0}}};
  localparam logic signed [SMP_W-1:0] S_MAX = {1'b0, {(SMP_W-1){1'b1}}};

  logic signed [SMP_W-1:0] err;
  logic        [SMP_W-1:0] mag;
  logic        [CMP_W-1:0] mag_x;
  logic        [CMP_W-1:0] rng_x;
  logic                    inr;

  // sign correction with saturation at the most negative code
  always_comb begin
    if (!pol)
      err = smp_data;
    else if (smp_data == S_MIN)
      err = S_MAX;
    else
      err = -smp_data;
  end

  // magnitude; the only code whose magnitude needs SMP_W bits is S_MIN
  always_comb begin
    if (err[SMP_W-1])
      mag = SMP_W'(-err);
    else
      mag = SMP_W'(err);
  end

  generate
    if (CMP_W > SMP_W) begin : g_pad_mag
      assign mag_x = {{(CMP_W-SMP_W){1'b0}}, mag};
    end else begin : g_raw_mag
      assign mag_x = mag;
    end
    if (CMP_W > RNG_W) begin : g_pad_rng
      assign rng_x = {{(CMP_W-RNG_W){1'b0}}, rng};
    end else begin : g_raw_rng
      assign rng_x = rng;
    end
  endgenerate

  assign inr = (mag_x <= rng_x);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      inr_q <= 1'b0;
    end else begin
      vld_q <= smp_valid && en;
      if (smp_valid)
        inr_q <= inr;
    end
  end

  // R3: most negative code is out of any window without negation
  a_r3_min_code_out: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !pol && smp_data == S_MIN) |=> !inr_q);

  // R3: with negation the most negative code saturates into a full window
  a_r3_sat_in: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && pol && smp_data == S_MIN && rng == {RNG_W{1'b1}}) |=> inr_q);

  // R2: zero error is always in range
  a_r2_zero_in: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && smp_data == '0) |=> inr_q);

endmodule

// File: rtl/esd_debounce.sv
module esd_debounce #(
  parameter int unsigned LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             hold_off,
  input  logic [LIM_W-1:0] lim,
  input  logic             vld,
  input  logic             inr,
  output logic             status
);
  import esd_pkg::*;

  localparam int unsigned CNT_W = LIM_W + 1;

  dec_e             dec_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             disagree;
  logic             flip;

  assign disagree = vld && (inr != (dec_q == DEC_SETTLED));
  assign cnt_inc  = cnt_q + CNT_W'(1);
  assign flip     = disagree && (cnt_inc >= {1'b0, lim});

  always_ff @(posedge clk) begin
    if (rst || !en || hold_off) begin
      dec_q <= DEC_OPEN;
      cnt_q <= '0;
    end else if (vld) begin
      if (flip) begin
        dec_q <= inr ? DEC_SETTLED : DEC_OPEN;
        cnt_q <= '0;
      end else if (disagree) begin
        cnt_q <= cnt_inc;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign status = (dec_q == DEC_SETTLED);

  // R8, R9: detection off keeps the flag low
  a_r9_hold_clear: assert property (@(posedge clk) disable iff (rst)
    (!en || hold_off) |=> !status);

  // R10: flag holds between strobes
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (en && !hold_off && !vld) |=> $stable(status));

  // R7: zero limit follows the sample
  a_r7_limit_zero: assert property (@(posedge clk) disable iff (rst)
    (en && !hold_off && vld && lim == '0) |=> (status == $past(inr)));

  // R4: a rise always comes from an in-range strobe
  a_r4_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(status) |-> $past(vld && inr));

  // R6: an agreeing sample restarts the count
  a_r6_restart: assert property (@(posedge clk) disable iff (rst)
    (vld && !disagree) |=> (cnt_q == '0));

endmodule

// File: rtl/err_settle_det.sv
module err_settle_det #(
  parameter int unsigned SMP_W = esd_pkg::DEF_SMP_W,
  parameter int unsigned RNG_W = esd_pkg::DEF_RNG_W,
  parameter int unsigned LIM_W = esd_pkg::DEF_LIM_W,
  localparam int unsigned CFG_W = 2 + RNG_W + LIM_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_wr,
  input  logic [CFG_W-1:0]        cfg_wdata,
  input  logic                    ramp_busy,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_data,
  output logic                    settled
);

  logic             en_q;
  logic             pol_q;
  logic [RNG_W-1:0] rng_q;
  logic [LIM_W-1:0] lim_q;
  logic             vld_q;
  logic             inr_q;

  esd_cfg_reg #(.RNG_W(RNG_W), .LIM_W(LIM_W)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .en_q  (en_q),
    .pol_q (pol_q),
    .rng_q (rng_q),
    .lim_q (lim_q)
  );

  esd_err_cond #(.SMP_W(SMP_W), .RNG_W(RNG_W)) u_cond (
    .clk       (clk),
    .rst       (rst),
    .en        (en_q),
    .pol       (pol_q),
    .rng       (rng_q),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .vld_q     (vld_q),
    .inr_q     (inr_q)
  );

  esd_debounce #(.LIM_W(LIM_W)) u_deb (
    .clk      (clk),
    .rst      (rst),
    .en       (en_q),
    .hold_off (ramp_busy),
    .lim      (lim_q),
    .vld      (vld_q),
    .inr      (inr_q),
    .status   (settled)
  );

  // R1: flag low in the cycle after reset
  a_r1_reset_low: assert property (@(posedge clk)
    $past(rst) |-> !settled);

endmodule

// File: tb/err_settle_det_bench.sv
module err_settle_det_bench;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_wr = 1'b0;
  logic [17:0]       cfg_wdata = '0;
  logic              ramp_busy = 1'b0;
  logic              smp_valid = 1'b0;
  logic signed [8:0] smp_data = '0;
  logic              settled;

  always #10 clk = ~clk;

  err_settle_det u_err_settle_det (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .ramp_busy (ramp_busy),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .settled   (settled)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit    exp_q[$];
  string tag_q[$];

  // reference model state
  bit m_en = 0, m_pol = 0, m_st = 0;
  int m_rng = 255, m_lim = 0, m_cnt = 0;

  task automatic check(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: settled=%0b expected %0b", tag, act, exp);
    end
  endtask

  // monitor: output is valid on the second edge after the sampling edge
  logic p1 = 0, p2 = 0;
  always @(posedge clk) begin
    p1 <= smp_valid;
    p2 <= p1;
  end
  always @(negedge clk) begin
    if (p2) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10: output with empty scoreboard, settled=%0b expected none", settled);
      end else begin
        check(tag_q.pop_front(), settled, exp_q.pop_front());
      end
    end
  end

  function automatic bit model_inr(input int x);
    int e;
    e = m_pol ? -x : x;
    if (e > 255) e = 255;
    if (e < 0) e = -e;
    return (e <= m_rng);
  endfunction

  task automatic send(input int x, input int gap, input string tag);
    bit inr;
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = 9'(x);
    inr = model_inr(x);
    if (!m_en || ramp_busy) begin
      m_st = 0; m_cnt = 0;
    end else if (inr != m_st) begin
      m_cnt++;
      if (m_cnt >= m_lim) begin m_st = inr; m_cnt = 0; end
    end else begin
      m_cnt = 0;
    end
    exp_q.push_back(m_st);
    tag_q.push_back(tag);
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  task automatic write_cfg(input bit en, input bit pol, input int rng, input int lim);
    drain();
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_wdata = {8'(rng), 8'(lim), pol, en};
    @(negedge clk);
    cfg_wr = 1'b0;
    m_en = en; m_pol = pol; m_rng = rng; m_lim = lim;
    if (!en) begin m_st = 0; m_cnt = 0; end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset", settled, 1'b0);

    // R1: disabled after reset
    for (int i = 0; i < 4; i++) send(0, 0, "R1 disabled");

    // R4 / R2: set after 3 in-range, boundary inclusive
    write_cfg(1, 0, 10, 3);
    send(0, 1, "R4 first");
    send(5, 0, "R4 second");
    send(-10, 2, "R2 boundary in / R4 third");
    // R10: holds across idle cycles
    repeat (6) begin @(negedge clk); check("R10 idle hold", settled, 1'b1); end
    // R5 / R6: clear needs 3 consecutive out
    send(11, 0, "R2 just out");
    send(-11, 0, "R5 second out");
    send(10, 0, "R6 restart");
    send(11, 1, "R5 out 1");
    send(100, 0, "R5 out 2");
    send(-200, 0, "R5 out 3 clears");
    // R6: interrupted rise
    send(1, 0, "R6 in 1");
    send(2, 0, "R6 in 2");
    send(50, 0, "R6 break");
    send(3, 3, "R6 in a");
    send(4, 0, "R6 in b");
    send(0, 0, "R6 in c sets");

    // R7: limit 0 follows each sample
    write_cfg(1, 0, 10, 0);
    send(3, 0, "R7 in");
    send(50, 0, "R7 out");
    send(-3, 0, "R7 in again");
    send(-11, 0, "R7 out again");

    // R3: saturating negation and polarity
    write_cfg(1, 1, 255, 0);
    send(-256, 0, "R3 saturated in");
    write_cfg(1, 0, 255, 0);
    send(-256, 0, "R3 no negation out");
    write_cfg(1, 1, 4, 0);
    send(-4, 0, "R3 pol1 edge in");
    send(5, 0, "R3 pol1 out");
    send(255, 0, "R3 pol1 max out");

    // R8: disable clears flag and counter
    write_cfg(1, 0, 10, 2);
    send(0, 0, "R8 setup 1");
    send(0, 0, "R8 setup 2");
    write_cfg(0, 0, 10, 2);
    check("R8 cleared", settled, 1'b0);
    write_cfg(1, 0, 10, 2);
    send(0, 0, "R8 partial count");
    write_cfg(0, 0, 10, 2);
    write_cfg(1, 0, 10, 2);
    send(0, 0, "R8 count restarted");
    send(0, 0, "R8 sets after two");

    // R9: ramp busy holds the flag low
    drain();
    @(negedge clk);
    ramp_busy = 1'b1;
    m_st = 0; m_cnt = 0;
    @(negedge clk);
    check("R9 busy clears", settled, 1'b0);
    send(0, 0, "R9 busy in 1");
    send(0, 0, "R9 busy in 2");
    send(0, 0, "R9 busy in 3");
    drain();
    @(negedge clk);
    ramp_busy = 1'b0;
    send(0, 0, "R9 after busy 1");
    send(0, 0, "R9 after busy 2 sets");

    drain();
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R10: %0d results missing, expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule